// File: doc/BRIEF.md
# USB Host Interrupt Register Block

This block holds the interrupt state of a small USB host controller. A byte-wide register bus reaches it. It collects single-cycle event pulses from the surrounding logic: completion of transfer engine A, completion of transfer engine B, the start-of-frame timer, device attach or detach, and either device detect or resume detect. Each pulse sets a sticky status bit. An enable register picks which of the set bits may drive one level-sensitive interrupt request line toward the host CPU.

Software learns why the interrupt fired by reading the status register. It acknowledges an event by writing a one to that bit. The top bit of the status register is different: it does not latch. It shows the synchronized state of the D+ line, which tells a full-speed device apart from a low-speed one after attach. Two control bits, held elsewhere in the register map, arrive as plain inputs. One lets start-of-frame events through. The other picks whether status bit 6 follows resume detection or device detection.

Top module: `usbh_irq_regblk`

## Requirements
- R1: After reset, every enable bit and every latched status bit is 0, and `irq_out` is low.
- R2: A pulse on an event input sets its status bit on the next clock edge, whatever the enable register holds. The status bits are: bit 0 for transfer A done, bit 1 for transfer B done, bit 4 for the SOF timer, bit 5 for insert/remove, and bit 6 for detect/resume.
- R3: Writing the status register at offset 0x0D clears each latched bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: `irq_out` is high exactly while at least one status bit is both set and enabled. It stays high until every such bit has been cleared or disabled. Setting an enable bit for a status bit that is already set raises `irq_out`.
- R5: The enable register at offset 0x06 reads back what was written in bits 0, 1, 4, 5 and 6. Bits 2, 3 and 7 read 0 and ignore writes.
- R6: In the status register, bits 2 and 3 always read 0. Any offset other than 0x06 and 0x0D reads 0x00. Read data follows `bus_addr` combinationally.
- R7: Status bit 7 shows `dplus_pin` after a two-flop synchronizer: a change is visible after the second clock edge and not after the first. A clear write does not change it, and it never drives `irq_out`.
- R8: When `ctl_resume_sel` is 1, status bit 6 is set by `ev_resume`. When it is 0, status bit 6 is set by `ev_dev_detect`. The input that is not selected has no effect.
- R9: `ev_sof_tick` sets status bit 4 only while `ctl_sof_en` is 1.
- R10: If an event pulse and a clear write hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| ctl_sof_en | input | 1 | Control: start-of-frame generation enabled |
| ctl_resume_sel | input | 1 | Control: bit 6 follows resume (1) or device detect (0) |
| ev_xfer_a_done | input | 1 | Pulse: transfer engine A finished |
| ev_xfer_b_done | input | 1 | Pulse: transfer engine B finished |
| ev_sof_tick | input | 1 | Pulse: SOF timer expired |
| ev_ins_rem | input | 1 | Pulse: device inserted or removed |
| ev_dev_detect | input | 1 | Pulse: device detected |
| ev_resume | input | 1 | Pulse: resume signalling detected |
| dplus_pin | input | 1 | Asynchronous D+ line level |
| irq_out | output | 1 | Level interrupt request |

## Verification
The bench latches events while their enables are off, then turns the enable on. A design that gated latching with the enable would stay silent here. It also checks that a design which drops the request while another enabled bit is still pending gets caught. It pulses an event in the same cycle as a clear of that bit. A design where the clear wins would lose the event. It samples bit 7 one edge and two edges after a D+ change, which catches a missing or extra synchronizer stage. It also writes ones to bit 7 and enables it, which catches a design that latches D+ or lets it raise the interrupt. Last, it drives the unselected detect/resume source and an SOF tick with its control bit off. A design that mixes the two bit-6 sources or fails to gate SOF would set a bit that must stay clear.

// File: rtl/usbh_irq_pkg.sv
// Package: shared offsets, bit positions and masks for the USB host
// interrupt register block. Assumes a byte-wide register bus.
package usbh_irq_pkg;
    localparam int          REG_AW      = 8;
    localparam int          REG_DW      = 8;
    localparam int          EV_CNT      = 5;
    localparam logic [7:0]  OFS_IRQ_EN  = 8'h06;
    localparam logic [7:0]  OFS_IRQ_ST  = 8'h0D;
    localparam int          BIT_XA      = 0;
    localparam int          BIT_XB      = 1;
    localparam int          BIT_SOF     = 4;
    localparam int          BIT_INSREM  = 5;
    localparam int          BIT_DETRES  = 6;
    localparam int          BIT_DPLUS   = 7;
    // Bits that latch events and may be enabled; others are reserved or live.
    localparam logic [7:0]  LATCH_MASK  = 8'h73;
endpackage

// File: rtl/usbh_irq_dsync.sv
// Module: multi-flop synchronizer for one asynchronous level input.
// Assumes the input is slow compared with clk; output resets to 0.
module usbh_irq_dsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/usbh_irq_evmap.sv
// Module: maps raw event pulses onto status-bit positions. Applies the
// SOF gate and the detect/resume source select. Purely combinational.
module usbh_irq_evmap
    import usbh_irq_pkg::*;
#(
    parameter int DW = REG_DW
) (
    input  logic          ctl_sof_en,
    input  logic          ctl_resume_sel,
    input  logic          ev_xfer_a_done,
    input  logic          ev_xfer_b_done,
    input  logic          ev_sof_tick,
    input  logic          ev_ins_rem,
    input  logic          ev_dev_detect,
    input  logic          ev_resume,
    output logic [DW-1:0] ev_vec
);
    // Place each qualified event at its status-bit position.
    always_comb begin
        ev_vec             = '0;
        ev_vec[BIT_XA]     = ev_xfer_a_done;
        ev_vec[BIT_XB]     = ev_xfer_b_done;
        ev_vec[BIT_SOF]    = ev_sof_tick & ctl_sof_en;
        ev_vec[BIT_INSREM] = ev_ins_rem;
        ev_vec[BIT_DETRES] = ctl_resume_sel ? ev_resume : ev_dev_detect;
    end
endmodule

// File: rtl/usbh_irq_stat_bank.sv
// Module: sticky status bits with write-one-to-clear. Only bits set in
// MASK get a flop; the rest read 0. A set in the same cycle as a
// clear wins.
module usbh_irq_stat_bank #(
    parameter int          DW   = 8,
    parameter logic [DW-1:0] MASK = 8'h73
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ev_vec,
    input  logic [DW-1:0] clr_vec,
    output logic [DW-1:0] stat_q
);
    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (MASK[i]) begin : g_live
            // Latch the event, drop on clear, hold otherwise.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stat_q[i] <= 1'b0;
                end else if (ev_vec[i]) begin
                    stat_q[i] <= 1'b1;
                end else if (clr_vec[i]) begin
                    stat_q[i] <= 1'b0;
                end
            end

            AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                ev_vec[i] |=> stat_q[i]);                                   // R10
            AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_vec[i] && !ev_vec[i]) |=> !stat_q[i]);                 // R3
            AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr_vec[i] && !ev_vec[i]) |=> $stable(stat_q[i]));        // R3
        end else begin : g_rsv
            assign stat_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/usbh_irq_regblk.sv
// Module: top of the USB host interrupt register block. Decodes the
// enable (0x06) and status (0x0D) offsets, returns read data
// combinationally and drives the level interrupt. Assumes bus_wr is
// a one-cycle strobe and that event inputs are synchronous pulses.
module usbh_irq_regblk
    import usbh_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_DW-1:0] bus_wdata,
    output logic [REG_DW-1:0] bus_rdata,
    input  logic              ctl_sof_en,
    input  logic              ctl_resume_sel,
    input  logic              ev_xfer_a_done,
    input  logic              ev_xfer_b_done,
    input  logic              ev_sof_tick,
    input  logic              ev_ins_rem,
    input  logic              ev_dev_detect,
    input  logic              ev_resume,
    input  logic              dplus_pin,
    output logic              irq_out
);
    localparam int SYNC_STAGES = 2;

    logic              sel_en;
    logic              sel_st;
    logic [REG_DW-1:0] en_q;
    logic [REG_DW-1:0] ev_vec;
    logic [REG_DW-1:0] clr_vec;
    logic [REG_DW-1:0] stat_q;
    logic              dplus_s;

    // Offset decode shared by the read and write paths.
    assign sel_en  = (bus_addr == OFS_IRQ_EN);
    assign sel_st  = (bus_addr == OFS_IRQ_ST);
    assign clr_vec = (bus_wr && sel_st) ? (bus_wdata & LATCH_MASK) : '0;

    usbh_irq_dsync #(.STAGES(SYNC_STAGES)) u_dsync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (dplus_pin),
        .q_sync  (dplus_s)
    );

    usbh_irq_evmap #(.DW(REG_DW)) u_evmap (
        .ctl_sof_en     (ctl_sof_en),
        .ctl_resume_sel (ctl_resume_sel),
        .ev_xfer_a_done (ev_xfer_a_done),
        .ev_xfer_b_done (ev_xfer_b_done),
        .ev_sof_tick    (ev_sof_tick),
        .ev_ins_rem     (ev_ins_rem),
        .ev_dev_detect  (ev_dev_detect),
        .ev_resume      (ev_resume),
        .ev_vec         (ev_vec)
    );

    usbh_irq_stat_bank #(.DW(REG_DW), .MASK(LATCH_MASK)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_vec  (ev_vec),
        .clr_vec (clr_vec),
        .stat_q  (stat_q)
    );

    // Enable register: writable only in the latching positions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (bus_wr && sel_en) begin
            en_q <= bus_wdata & LATCH_MASK;
        end
    end

    // Read mux: enable, status with live D+, or zero.
    always_comb begin
        bus_rdata = '0;
        if (sel_en) begin
            bus_rdata = en_q;
        end else if (sel_st) begin
            bus_rdata            = stat_q;
            bus_rdata[BIT_DPLUS] = dplus_s;
        end
    end

    // Level interrupt: any latched bit that is also enabled.
    assign irq_out = |(stat_q & en_q);

    AST_IRQ_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !(bus_wr && (sel_en || sel_st))) |=> irq_out);          // R4
    AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_st || sel_en) |-> (bus_rdata[3:2] == 2'b00));                  // R6
    AST_OTHER_OFS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_st && !sel_en) |-> (bus_rdata == '0));                        // R6
    AST_SOF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_q[BIT_SOF] && !ctl_sof_en) |=> !stat_q[BIT_SOF]);            // R9
    AST_EN_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q & ~LATCH_MASK) == '0);                                        // R5
endmodule

// File: tb/usbh_irq_regblk_tb.sv
// Directed bench for usbh_irq_regblk: one task per scenario.
module usbh_irq_regblk_tb;
    localparam time CLK_P = 20ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ctl_sof_en = 1'b0;
    logic       ctl_resume_sel = 1'b0;
    logic       ev_xfer_a_done = 1'b0;
    logic       ev_xfer_b_done = 1'b0;
    logic       ev_sof_tick = 1'b0;
    logic       ev_ins_rem = 1'b0;
    logic       ev_dev_detect = 1'b0;
    logic       ev_resume = 1'b0;
    logic       dplus_pin = 1'b0;
    logic       irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    usbh_irq_regblk u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctl_sof_en(ctl_sof_en), .ctl_resume_sel(ctl_resume_sel),
        .ev_xfer_a_done(ev_xfer_a_done), .ev_xfer_b_done(ev_xfer_b_done),
        .ev_sof_tick(ev_sof_tick), .ev_ins_rem(ev_ins_rem),
        .ev_dev_detect(ev_dev_detect), .ev_resume(ev_resume),
        .dplus_pin(dplus_pin), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // mask: 0 A, 1 B, 2 SOF, 3 ins/rem, 4 detect, 5 resume
    task automatic pulse(input logic [5:0] m);
        @(negedge clk);
        {ev_resume, ev_dev_detect, ev_ins_rem, ev_sof_tick, ev_xfer_b_done, ev_xfer_a_done} = m;
        @(negedge clk);
        {ev_resume, ev_dev_detect, ev_ins_rem, ev_sof_tick, ev_xfer_b_done, ev_xfer_a_done} = '0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(8'h06, v); check("R1 enable after reset", v, 8'h00);
        rd(8'h0D, v); check("R1 status after reset", v, 8'h00);
        check("R1 irq after reset", {7'd0, irq_out}, 8'h00);
    endtask

    task automatic t_latch_disabled();
        logic [7:0] v;
        ctl_sof_en = 1'b1; ctl_resume_sel = 1'b0;
        pulse(6'b011111);
        rd(8'h0D, v); check("R2 all events latch while disabled", v, 8'h73);
        check("R2 irq low with enables off", {7'd0, irq_out}, 8'h00);
        wr(8'h0D, 8'h73);
        rd(8'h0D, v); check("R3 clear all", v, 8'h00);
        ctl_sof_en = 1'b0;
    endtask

    task automatic t_w1c();
        logic [7:0] v;
        pulse(6'b001011);
        wr(8'h0D, 8'h02);
        rd(8'h0D, v); check("R3 clear only bit1", v, 8'h21);
        wr(8'h0D, 8'h00);
        rd(8'h0D, v); check("R3 zero write keeps bits", v, 8'h21);
        wr(8'h0D, 8'hFF);
        rd(8'h0D, v); check("R3 clear rest", v, 8'h00);
    endtask

    task automatic t_irq_level();
        logic [7:0] v;
        pulse(6'b000001);
        check("R4 irq low before enable", {7'd0, irq_out}, 8'h00);
        wr(8'h06, 8'h03);
        check("R4 enable of pending bit raises irq", {7'd0, irq_out}, 8'h01);
        pulse(6'b000010);
        wr(8'h0D, 8'h01);
        check("R4 irq held by remaining bit", {7'd0, irq_out}, 8'h01);
        wr(8'h0D, 8'h02);
        check("R4 irq drops when all cleared", {7'd0, irq_out}, 8'h00);
        pulse(6'b001000);
        check("R4 disabled bit no irq", {7'd0, irq_out}, 8'h00);
        wr(8'h0D, 8'h20);
        rd(8'h0D, v); check("R3 cleared ins/rem", v, 8'h00);
        wr(8'h06, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(8'h06, 8'hFF);
        rd(8'h06, v); check("R5 enable reserved bits read 0", v, 8'h73);
        wr(8'h06, 8'h50);
        rd(8'h06, v); check("R5 enable readback", v, 8'h50);
        wr(8'h06, 8'h00);
        pulse(6'b011111);
        ctl_sof_en = 1'b0;
        rd(8'h0D, v); check("R6 status reserved bits read 0", v & 8'h0C, 8'h00);
        rd(8'h05, v); check("R6 other offset reads 0", v, 8'h00);
        rd(8'h0E, v); check("R6 offset 0E reads 0", v, 8'h00);
        wr(8'h0D, 8'hFF);
    endtask

    task automatic t_dplus();
        logic [7:0] v;
        @(negedge clk); dplus_pin = 1'b1;
        @(negedge clk); rd(8'h0D, v); check("R7 one edge not yet visible", v, 8'h00);
        @(negedge clk); rd(8'h0D, v); check("R7 visible after two edges", v, 8'h80);
        wr(8'h0D, 8'h80);
        rd(8'h0D, v); check("R7 clear write no effect", v, 8'h80);
        wr(8'h06, 8'hFF);
        check("R7 D+ never raises irq", {7'd0, irq_out}, 8'h00);
        wr(8'h06, 8'h00);
        @(negedge clk); dplus_pin = 1'b0;
        repeat (2) @(negedge clk);
        rd(8'h0D, v); check("R7 follows D+ low", v, 8'h00);
    endtask

    task automatic t_sel();
        logic [7:0] v;
        ctl_resume_sel = 1'b0;
        pulse(6'b100000);
        rd(8'h0D, v); check("R8 resume ignored in detect mode", v, 8'h00);
        pulse(6'b010000);
        rd(8'h0D, v); check("R8 detect sets bit6", v, 8'h40);
        wr(8'h0D, 8'h40);
        ctl_resume_sel = 1'b1;
        pulse(6'b010000);
        rd(8'h0D, v); check("R8 detect ignored in resume mode", v, 8'h00);
        pulse(6'b100000);
        rd(8'h0D, v); check("R8 resume sets bit6", v, 8'h40);
        wr(8'h0D, 8'h40);
        ctl_resume_sel = 1'b0;
    endtask

    task automatic t_sof();
        logic [7:0] v;
        ctl_sof_en = 1'b0;
        pulse(6'b000100);
        rd(8'h0D, v); check("R9 SOF ignored when gated", v, 8'h00);
        ctl_sof_en = 1'b1;
        pulse(6'b000100);
        rd(8'h0D, v); check("R9 SOF latches when enabled", v, 8'h10);
        wr(8'h0D, 8'h10);
        ctl_sof_en = 1'b0;
    endtask

    task automatic t_set_wins();
        logic [7:0] v;
        pulse(6'b000001);
        @(negedge clk);
        bus_addr = 8'h0D; bus_wdata = 8'h01; bus_wr = 1'b1; ev_xfer_a_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; ev_xfer_a_done = 1'b0;
        rd(8'h0D, v); check("R10 set beats clear", v, 8'h01);
        wr(8'h0D, 8'h01);
        rd(8'h0D, v); check("R10 later clear works", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch_disabled();
        t_w1c();
        t_irq_level();
        t_regs();
        t_dplus();
        t_sel();
        t_sof();
        t_set_wins();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule